// File: doc/BRIEF.md
# CAN Receive Message FIFO

This block holds received CAN messages that the acceptance filter has passed until the CPU has read them. All pending messages share one 64-byte ring, and each message takes only as many bytes as its frame needs. A frame receiver streams the bytes of a frame into the write side. It then ends the frame with an accept pulse, which keeps the message, or a reject pulse, which discards it. A new frame can arrive while the CPU is still reading an earlier message.

The CPU reads through a fixed 13-byte window. Window byte 0 is always the first byte of the oldest stored message. A release command frees that message, and the window then slides to the next message. A message counter, a data-available flag and a sticky overrun flag report the state of the FIFO. The overrun flag marks an accepted frame that had to be dropped because there was not enough free space.

Top module: `can_rx_msg_fifo`

## Requirements
- R1: Storage is one ring of 64 bytes shared by all pending messages. Window byte `rd_addr` = i (i below the message length) returns the i-th byte stored for the oldest message. Ring addresses wrap modulo 64, so a message may straddle the end of the ring.
- R2: The first byte of a frame is its info byte: bit 7 = extended format, bit 6 = remote request, bits 3:0 = length code. Stored length is 3 bytes (standard) or 5 bytes (extended), plus min(code, 8) data bytes, and no data bytes when bit 6 is set. Bytes sent past that length are ignored.
- R3: A reject pulse during a frame leaves the message count, the stored messages and the window unchanged.
- R4: An accept pulse during a frame stores the whole message and raises the message count by one in the next cycle. Accept takes priority over reject if both are high.
- R5: A release with at least one message pending frees the oldest message, and the window moves to the next one. A release with no message pending is ignored, and the count never underflows.
- R6: If an accepted frame does not fit in the free space, checked when its info byte arrives, the whole frame is dropped, stored messages are untouched and `overrun` is set. `clr_ovr` clears `overrun`, but a drop in the same cycle leaves it set.
- R7: `data_avail` is high exactly when `msg_count` is non-zero.
- R8: Frame bytes can be written while the CPU reads the window, and a release can occur in the same cycle as a frame byte.
- R9: A window address of 13 or more reads as 0.
- R10: After reset, `msg_count` is 0 and `data_avail` and `overrun` are low.
- R11: Accept and reject pulses outside a frame are ignored. The first valid byte after a frame ends, or after reset, is taken as the next info byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A frame byte is present on `wr_byte` |
| wr_byte | input | 8 | Frame byte from the receiver |
| wr_accept | input | 1 | Filter passed the current frame |
| wr_reject | input | 1 | Filter refused the current frame |
| rd_addr | input | 4 | Byte index inside the receive window |
| rd_data | output | 8 | Window byte (combinational) |
| rel | input | 1 | Release the oldest message |
| clr_ovr | input | 1 | Clear the overrun flag |
| msg_count | output | 5 | Number of stored messages |
| data_avail | output | 1 | At least one message is stored |
| overrun | output | 1 | An accepted frame was dropped for lack of space |

## Verification
Most internal faults first become visible as a wrong window byte. A corrupted read pointer or occupancy shifts every window byte after the next release. A wrong length decode moves the start of the following message, which shows at window byte 0 one release later. A wrong fit check shows as a wrong `overrun` or count in the cycle after the accept pulse. Because the reference model checks the whole window of the oldest message every cycle, a fault is reported no later than the release that exposes the affected message.

// File: rtl/can_rxf_pkg.sv
`timescale 1ns/1ps
package can_rxf_pkg;
  localparam int INFO_EXT_BIT = 7;
  localparam int INFO_RTR_BIT = 6;
  localparam int DATA_MAX     = 8;

  // Stored bytes of one message, decoded from its info byte.
  function automatic logic [3:0] msg_len(input logic [7:0] info);
    logic [3:0] dat;
    logic [3:0] hdr;
    dat = (info[3:0] > 4'(DATA_MAX)) ? 4'(DATA_MAX) : info[3:0];
    if (info[INFO_RTR_BIT]) dat = 4'd0;
    hdr = info[INFO_EXT_BIT] ? 4'd5 : 4'd3;
    return hdr + dat;
  endfunction
endpackage

// File: rtl/rxf_store.sv
`timescale 1ns/1ps
module rxf_store #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] win_addr,
  output logic [7:0]    win_data,
  input  logic [AW-1:0] head_addr,
  output logic [7:0]    head_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign win_data  = mem[win_addr];
  assign head_data = mem[head_addr];
endmodule

// File: rtl/rxf_wr_ctrl.sv
`timescale 1ns/1ps
module rxf_wr_ctrl
  import can_rxf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int UW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [7:0]    wr_byte,
  input  logic          wr_accept,
  input  logic          wr_reject,
  input  logic [AW-1:0] base,
  input  logic [UW-1:0] used,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic          commit_evt,
  output logic          drop_evt,
  output logic          reject_evt,
  output logic [3:0]    commit_len
);
  logic       in_frame, dropping;
  logic [3:0] wcnt, need;
  logic       start, fits;
  logic [3:0] new_len;
  logic [UW-1:0] free_bytes;

  assign new_len    = msg_len(wr_byte);
  assign free_bytes = UW'(DEPTH) - used;
  assign fits       = free_bytes >= UW'(new_len);
  assign start      = wr_valid && !in_frame;

  assign mem_we    = wr_valid && (start ? fits : (!dropping && wcnt < need));
  assign mem_waddr = start ? base : base + AW'(wcnt);
  assign mem_wdata = wr_byte;

  assign commit_evt = in_frame && wr_accept && !dropping;
  assign drop_evt   = in_frame && wr_accept && dropping;
  assign reject_evt = in_frame && wr_reject && !wr_accept;
  assign commit_len = need;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      dropping <= 1'b0;
      wcnt     <= '0;
      need     <= '0;
    end else if (start) begin
      in_frame <= 1'b1;
      dropping <= !fits;
      need     <= new_len;
      wcnt     <= 4'd1;
    end else if (in_frame) begin
      if (wr_valid && wcnt < need) wcnt <= wcnt + 4'd1;
      if (wr_accept || wr_reject) in_frame <= 1'b0;
    end
  end
endmodule

// File: rtl/rxf_occupancy.sv
`timescale 1ns/1ps
module rxf_occupancy
  import can_rxf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int UW = $clog2(DEPTH + 1),
  localparam int CW = $clog2(DEPTH / 3 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit_evt,
  input  logic [3:0]    commit_len,
  input  logic          rel_req,
  input  logic [7:0]    head_info,
  output logic          release_evt,
  output logic [AW-1:0] rptr,
  output logic [UW-1:0] used,
  output logic [CW-1:0] count
);
  logic [3:0]    rel_len;
  logic [UW-1:0] used_n;
  logic [CW-1:0] count_n;

  assign release_evt = rel_req && (count != '0);
  assign rel_len     = msg_len(head_info);

  always_comb begin
    used_n  = used;
    count_n = count;
    if (commit_evt) begin
      used_n  = used_n + UW'(commit_len);
      count_n = count_n + CW'(1);
    end
    if (release_evt) begin
      used_n  = used_n - UW'(rel_len);
      count_n = count_n - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      used  <= '0;
      count <= '0;
    end else begin
      used  <= used_n;
      count <= count_n;
      if (release_evt) rptr <= rptr + AW'(rel_len);
    end
  end
endmodule

// File: rtl/can_rx_msg_fifo.sv
`timescale 1ns/1ps
module can_rx_msg_fifo #(
  parameter int DEPTH = 64,
  parameter int WIN   = 13,
  localparam int AW  = $clog2(DEPTH),
  localparam int UW  = $clog2(DEPTH + 1),
  localparam int CW  = $clog2(DEPTH / 3 + 1),
  localparam int WAW = $clog2(WIN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_valid,
  input  logic [7:0]     wr_byte,
  input  logic           wr_accept,
  input  logic           wr_reject,
  input  logic [WAW-1:0] rd_addr,
  output logic [7:0]     rd_data,
  input  logic           rel,
  input  logic           clr_ovr,
  output logic [CW-1:0]  msg_count,
  output logic           data_avail,
  output logic           overrun
);
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata;
  logic          commit_evt, drop_evt, reject_evt, release_evt;
  logic [3:0]    commit_len;
  logic [AW-1:0] rptr, base, win_addr;
  logic [UW-1:0] used;
  logic [CW-1:0] count;
  logic [7:0]    win_byte, head_info;

  // Next free byte: read pointer plus occupancy, wrapping around the ring.
  assign base     = rptr + AW'(used);
  assign win_addr = rptr + AW'(rd_addr);

  rxf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk, .rst_n, .wr_valid, .wr_byte, .wr_accept, .wr_reject,
    .base, .used, .mem_we, .mem_waddr, .mem_wdata,
    .commit_evt, .drop_evt, .reject_evt, .commit_len
  );

  rxf_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk, .rst_n, .commit_evt, .commit_len, .rel_req(rel),
    .head_info, .release_evt, .rptr, .used, .count
  );

  rxf_store #(.DEPTH(DEPTH)) u_mem (
    .clk, .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .win_addr, .win_data(win_byte), .head_addr(rptr), .head_data(head_info)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        overrun <= 1'b0;
    else if (drop_evt) overrun <= 1'b1;
    else if (clr_ovr)  overrun <= 1'b0;
  end

  assign rd_data    = (int'(rd_addr) < WIN) ? win_byte : 8'h00;
  assign msg_count  = count;
  assign data_avail = (count != '0);
endmodule

// File: rtl/can_rx_msg_fifo_chk.sv
`timescale 1ns/1ps
module can_rx_msg_fifo_chk #(
  parameter int DEPTH = 64,
  localparam int UW = $clog2(DEPTH + 1),
  localparam int CW = $clog2(DEPTH / 3 + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [UW-1:0] used,
  input logic [CW-1:0] count,
  input logic          commit_evt,
  input logic          release_evt,
  input logic          drop_evt,
  input logic          reject_evt,
  input logic          rel,
  input logic          clr_ovr,
  input logic          overrun
);
  AST_USED_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    used <= UW'(DEPTH)); // R1
  AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) == (used == '0)); // R7
  AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt && !release_evt |=> count == $past(count) && used == $past(used)); // R3
  AST_COMMIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt && !release_evt |=> count == $past(count) + CW'(1)); // R4
  AST_EMPTY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    rel && count == '0 && !commit_evt |=> count == '0); // R5
  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt && !release_evt |=> used == $past(used) && overrun); // R6
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !clr_ovr |=> overrun); // R6
endmodule

bind can_rx_msg_fifo can_rx_msg_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .used(used), .count(count),
  .commit_evt(commit_evt), .release_evt(release_evt), .drop_evt(drop_evt),
  .reject_evt(reject_evt), .rel(rel), .clr_ovr(clr_ovr), .overrun(overrun)
);

// File: tb/can_rx_msg_fifo_test.sv
`timescale 1ns/1ps
module can_rx_msg_fifo_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 0, wr_accept = 0, wr_reject = 0, rel = 0, clr_ovr = 0;
  logic [7:0] wr_byte = 0;
  logic [3:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic [4:0] msg_count;
  logic data_avail, overrun;

  int total = 0, bad = 0;
  bit done = 0;
  int seed = 8'h21;

  // reference model: flat byte queue of stored messages plus their lengths
  byte unsigned mb[$];
  int ml[$];
  byte unsigned cur[$];
  bit m_in = 0, m_drop = 0, m_ovr = 0;
  int m_need = 0;

  always #5 clk = ~clk;

  can_rx_msg_fifo uut (
    .clk, .rst_n, .wr_valid, .wr_byte, .wr_accept, .wr_reject,
    .rd_addr, .rd_data, .rel, .clr_ovr, .msg_count, .data_avail, .overrun
  );

  function automatic int ref_len(input byte unsigned info);
    int d;
    d = info[3:0];
    if (d > 8) d = 8;
    if (info[6]) d = 0;
    return d + (info[7] ? 5 : 3);
  endfunction

  task automatic chk_eq(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_update();
    bit pre_in;
    int pre_used, pre_cnt;
    bit set_ovr;
    pre_in = m_in; pre_used = mb.size(); pre_cnt = ml.size(); set_ovr = 0;
    if (rel && pre_cnt > 0) begin
      for (int i = 0; i < ml[0]; i++) void'(mb.pop_front());
      void'(ml.pop_front());
    end
    if (wr_valid) begin
      if (!pre_in) begin
        m_need = ref_len(wr_byte);
        m_drop = (64 - pre_used) < m_need;
        cur.delete();
        if (!m_drop) cur.push_back(wr_byte);
        m_in = 1;
      end else if (!m_drop && cur.size() < m_need) cur.push_back(wr_byte);
    end
    if (pre_in && (wr_accept || wr_reject)) begin
      if (wr_accept) begin
        if (m_drop) set_ovr = 1;
        else begin
          foreach (cur[i]) mb.push_back(cur[i]);
          ml.push_back(m_need);
        end
      end
      m_in = 0;
    end
    if (clr_ovr) m_ovr = 0;
    if (set_ovr) m_ovr = 1;
  endtask

  task automatic compare();
    chk_eq(msg_count, ml.size(), "R4 message count");
    chk_eq(data_avail, ml.size() != 0, "R7 data available");
    chk_eq(overrun, m_ovr, "R6 overrun flag");
    if (ml.size() > 0)
      for (int i = 0; i < ml[0]; i++) begin
        rd_addr = 4'(i);
        #0.2;
        chk_eq(rd_data, mb[i], "R1 window byte");
      end
    rd_addr = 0;
  endtask

  task automatic cyc(input bit v, input logic [7:0] b, input bit acc, input bit rej,
                     input bit r, input bit c);
    wr_valid = v; wr_byte = b; wr_accept = acc; wr_reject = rej; rel = r; clr_ovr = c;
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  // R2: info byte, header bytes, data bytes, optional extra bytes, then verdict
  task automatic send(input bit ext, input bit rtr, input int dlc, input bit acc,
                      input int extra, input bit rel_mid);
    logic [7:0] info;
    int n;
    info = {ext, rtr, 2'b00, 4'(dlc)};
    n = ref_len(info);
    cyc(1, info, 0, 0, 0, 0);
    for (int i = 1; i < n + extra; i++) begin
      seed = (seed * 37 + 11) % 251;
      cyc(1, 8'(seed), 0, 0, rel_mid && i == 1, 0);
    end
    cyc(0, 0, acc, !acc, 0, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R10 watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_eq(msg_count, 0, "R10 reset count");
    chk_eq(data_avail, 0, "R10 reset avail");
    chk_eq(overrun, 0, "R10 reset overrun");
    send(0, 0, 2, 1, 0, 0);          // R4 standard, 5 bytes
    send(1, 0, 8, 1, 0, 0);          // R4 extended, 13 bytes
    send(0, 0, 4, 0, 0, 0);          // R3 rejected
    send(0, 1, 5, 1, 0, 0);          // R2 remote request, 3 bytes
    send(0, 0, 15, 1, 3, 0);         // R2 code capped, extra bytes ignored
    cyc(0, 0, 1, 0, 0, 0);           // R11 stray accept
    cyc(0, 0, 0, 1, 0, 0);           // R11 stray reject
    for (int a = 13; a < 16; a++) begin
      rd_addr = 4'(a);
      #0.2;
      chk_eq(rd_data, 0, "R9 out-of-window read");
    end
    rd_addr = 0;
    cyc(0, 0, 0, 0, 1, 0);           // R5 release
    cyc(0, 0, 0, 0, 1, 0);
    for (int k = 0; k < 4; k++) send(1, 0, 8, 1, 0, 0); // R6 last one dropped
    send(0, 0, 0, 1, 0, 0);
    send(1, 0, 8, 0, 0, 0);          // R6 rejected oversize frame sets nothing
    cyc(0, 0, 0, 0, 0, 1);           // R6 clear
    send(1, 0, 8, 1, 0, 0);          // R6 drop again
    cyc(0, 0, 0, 0, 0, 1);
    chk_eq(overrun, 0, "R6 cleared");
    for (int k = 0; k < 10; k++) cyc(0, 0, 0, 0, 1, 0); // R5 drain and empty releases
    chk_eq(msg_count, 0, "R5 no underflow");
    for (int k = 0; k < 30; k++) begin   // R8 R1 concurrent release, ring wrap
      send(k[0], k % 5 == 4, k % 11, k % 7 != 3, k % 3, 1);
      if (k % 4 == 0) cyc(0, 0, 0, 0, 1, 0);
    end
    for (int k = 0; k < 25; k++) cyc(0, 0, 0, 0, 1, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule